// File: doc/BRIEF.md
# Programmable Decade Down-Counter Divider

This block divides an incoming pulse stream by a number set on decimal switches. A toggle stage first halves the incoming rate. Each resulting counting pulse decrements a chain of BCD decades. The least significant decade takes every counting pulse. Every higher decade steps once each time the most significant bit of the decade below it falls. The most significant bit of the top decade is inverted and sent out as the count signal, which clocks the next, more significant divider stage.

A downstream stage watches the digits. When they reach its chosen value, it raises a reload request. The block then opens an eight-pulse window, and it counts none of the pulses that arrive inside it. During the first part of the window every decade is forced to all ones. The middle part holds that value. In the last part every decade takes fifteen minus its switch digit, with any switch digit above nine treated as nine. Normal counting starts again on the pulse after the window closes.

Top module: `bcd_preset_divider`

## Requirements
- R1: While rst_ni is low, every decade is 0000 and count_o is 1.
- R2: A toggle flip-flop, cleared by reset, flips on every in_pulse_i. Only an in_pulse_i that arrives while the flip-flop is 1 is a counting pulse, so the second, fourth, sixth and later inputs count.
- R3: Outside the reload window, each counting pulse decrements the lowest decade by one. 0000 becomes 1001, and values above nine also drop by one.
- R4: Decade k+1 decrements in the same clock as decade k only if that step takes bit 3 of decade k from 1 to 0.
- R5: count_o always equals the inverse of bit 3 of the top decade.
- R6: If reload_req_i is high on a clock edge while no window is open, an eight-pulse window opens. A counting pulse on that same edge is the window's first pulse.
- R7: Window pulses 1 and 2 set every decade to 1111.
- R8: Window pulses 3 to 5 leave every decade unchanged.
- R9: Window pulses 6 to 8 load decade k with 15 minus min(switch digit k, 9). Switch digit k is preset_sw_i[4k+3:4k]. The window closes on pulse 8, and pulse 9 decrements under R3.
- R10: A reload_req_i that arrives while a window is open has no effect on the window's progress or on the digits.
- R11: The digits change only on a clock edge that carries a counting pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_pulse_i | input | 1 | Incoming pulse, one clock wide, before the divide-by-two |
| reload_req_i | input | 1 | Reload request from the downstream stage |
| preset_sw_i | input | 4*NUM_DIGITS | Switch digits, decade 0 in the low nibble |
| digits_o | output | 4*NUM_DIGITS | Decade registers, decade 0 in the low nibble |
| count_o | output | 1 | Inverted top-decade bit 3, drives the next stage |

## Verification
The bench uses the default parameters: two decades and a 2/3/3 window split. With two decades a full wrap through every digit pair takes a few hundred cycles. Every window phase can be reached with random reload requests. Random switch digits include values above nine, so the clamp in the preset is exercised. Reload requests land at random points, some with a counting pulse on the same edge and some inside an open window.

// File: rtl/bcd_div_pkg.sv
`timescale 1ns/1ps
package bcd_div_pkg;
  localparam int unsigned DIG_W = 4;

  typedef enum logic [1:0] {
    ACT_COUNT = 2'd0,
    ACT_INIT  = 2'd1,
    ACT_HOLD  = 2'd2,
    ACT_LOAD  = 2'd3
  } dig_act_e;

  function automatic logic [DIG_W-1:0] bcd_dec(input logic [DIG_W-1:0] d);
    return (d == '0) ? DIG_W'(9) : d - DIG_W'(1);
  endfunction

  function automatic logic [DIG_W-1:0] preset_of(input logic [DIG_W-1:0] sw);
    logic [DIG_W-1:0] s;
    s = (sw > DIG_W'(9)) ? DIG_W'(9) : sw;
    return DIG_W'(15) - s;
  endfunction
endpackage

// File: rtl/bcd_div_prescale.sv
`timescale 1ns/1ps
module bcd_div_prescale (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_pulse_i,
  output logic step_o
);
  logic tff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tff_q <= 1'b0;
    else if (in_pulse_i) tff_q <= ~tff_q;
  end

  assign step_o = in_pulse_i & tff_q;

  p_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pulse_i |=> (tff_q != $past(tff_q)));
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_pulse_i |=> $stable(tff_q));
endmodule

// File: rtl/bcd_div_seq.sv
`timescale 1ns/1ps
module bcd_div_seq #(
  parameter int unsigned INIT_LEN = 2,
  parameter int unsigned HOLD_LEN = 3,
  parameter int unsigned LOAD_LEN = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  step_i,
  input  logic                  reload_req_i,
  output bcd_div_pkg::dig_act_e act_o,
  output logic                  busy_o
);
  localparam int unsigned WIN_LEN = INIT_LEN + HOLD_LEN + LOAD_LEN;
  localparam int unsigned PH_W    = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [PH_W-1:0] LAST_IDX = PH_W'(WIN_LEN - 1);

  logic            win_q;
  logic [PH_W-1:0] ph_q;
  logic            accept, live;
  logic [PH_W-1:0] idx;

  assign accept = reload_req_i & ~win_q;
  assign live   = win_q | accept;
  assign idx    = accept ? '0 : ph_q;

  always_comb begin
    if (!live)                                   act_o = bcd_div_pkg::ACT_COUNT;
    else if (int'(idx) < int'(INIT_LEN))         act_o = bcd_div_pkg::ACT_INIT;
    else if (int'(idx) < int'(INIT_LEN + HOLD_LEN)) act_o = bcd_div_pkg::ACT_HOLD;
    else                                         act_o = bcd_div_pkg::ACT_LOAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= 1'b0;
      ph_q  <= '0;
    end else if (step_i && live) begin
      if (idx == LAST_IDX) begin
        win_q <= 1'b0;
        ph_q  <= '0;
      end else begin
        win_q <= 1'b1;
        ph_q  <= idx + PH_W'(1);
      end
    end else if (accept) begin
      win_q <= 1'b1;
      ph_q  <= '0;
    end
  end

  assign busy_o = win_q;

  p_ph_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ph_q) < int'(WIN_LEN));
  p_open_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_q && reload_req_i && !step_i) |=> (win_q && ph_q == '0));
  p_close_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q && step_i && ph_q == LAST_IDX) |=> !win_q);
  p_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q && reload_req_i && !step_i) |=> (win_q && $stable(ph_q)));
endmodule

// File: rtl/bcd_div_digit.sv
`timescale 1ns/1ps
module bcd_div_digit (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                step_i,
  input  logic                                carry_i,
  input  bcd_div_pkg::dig_act_e               act_i,
  input  logic [bcd_div_pkg::DIG_W-1:0]       sw_i,
  output logic [bcd_div_pkg::DIG_W-1:0]       digit_o,
  output logic                                borrow_o
);
  localparam int unsigned W = bcd_div_pkg::DIG_W;

  logic [W-1:0] d_q, d_nxt;

  always_comb begin
    d_nxt    = d_q;
    borrow_o = 1'b0;
    unique case (act_i)
      bcd_div_pkg::ACT_COUNT: if (step_i && carry_i) begin
        d_nxt    = bcd_div_pkg::bcd_dec(d_q);
        borrow_o = d_q[W-1] & ~d_nxt[W-1];  // MSB falling edge ripples on
      end
      bcd_div_pkg::ACT_INIT:  if (step_i) d_nxt = '1;
      bcd_div_pkg::ACT_HOLD:  d_nxt = d_q;
      bcd_div_pkg::ACT_LOAD:  if (step_i) d_nxt = bcd_div_pkg::preset_of(sw_i);
      default:                d_nxt = d_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= '0;
    else         d_q <= d_nxt;
  end

  assign digit_o = d_q;

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(digit_o));
  p_inhibit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == bcd_div_pkg::ACT_HOLD) |=> $stable(digit_o));
  p_bcd_stays_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && carry_i && act_i == bcd_div_pkg::ACT_COUNT && d_q <= W'(9)) |=> (digit_o <= W'(9)));
endmodule

// File: rtl/bcd_preset_divider.sv
`timescale 1ns/1ps
module bcd_preset_divider #(
  parameter int unsigned NUM_DIGITS = 2,
  parameter int unsigned INIT_LEN   = 2,
  parameter int unsigned HOLD_LEN   = 3,
  parameter int unsigned LOAD_LEN   = 3
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       in_pulse_i,
  input  logic                                       reload_req_i,
  input  logic [NUM_DIGITS*bcd_div_pkg::DIG_W-1:0]   preset_sw_i,
  output logic [NUM_DIGITS*bcd_div_pkg::DIG_W-1:0]   digits_o,
  output logic                                       count_o
);
  localparam int unsigned W     = bcd_div_pkg::DIG_W;
  localparam int unsigned TOP_B = NUM_DIGITS*W - 1;

  logic                  step;
  logic                  busy;
  bcd_div_pkg::dig_act_e act;
  logic [NUM_DIGITS:0]   carry;

  bcd_div_prescale u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_pulse_i (in_pulse_i),
    .step_o     (step)
  );

  bcd_div_seq #(
    .INIT_LEN (INIT_LEN),
    .HOLD_LEN (HOLD_LEN),
    .LOAD_LEN (LOAD_LEN)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (step),
    .reload_req_i (reload_req_i),
    .act_o        (act),
    .busy_o       (busy)
  );

  assign carry[0] = 1'b1;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
    bcd_div_digit u_dig (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (step),
      .carry_i  (carry[g]),
      .act_i    (act),
      .sw_i     (preset_sw_i[g*W +: W]),
      .digit_o  (digits_o[g*W +: W]),
      .borrow_o (carry[g+1])
    );
  end

  assign count_o = ~digits_o[TOP_B];

  p_count_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry[NUM_DIGITS] |=> count_o);
  p_count_track_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |-> (digits_o != $past(digits_o)));
  p_init_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && act == bcd_div_pkg::ACT_INIT) |=> (&digits_o));
  p_busy_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !step) |=> (busy && $stable(digits_o)));
endmodule

// File: tb/bcd_preset_divider_test.sv
`timescale 1ns/1ps
module bcd_preset_divider_test;
  localparam int ND = 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_pulse = 1'b0;
  logic            req = 1'b0;
  logic [ND*4-1:0] sw = '0;
  logic [ND*4-1:0] digits;
  logic            count;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [3:0] m_d [ND];
  bit         m_tff, m_win;
  int         m_ph;
  string      m_tag;

  always #5 clk = ~clk;

  bcd_preset_divider #(.NUM_DIGITS(ND)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .in_pulse_i   (in_pulse),
    .reload_req_i (req),
    .preset_sw_i  (sw),
    .digits_o     (digits),
    .count_o      (count)
  );

  function automatic logic [3:0] f_preset(input logic [3:0] s);
    return 4'd15 - ((s > 4'd9) ? 4'd9 : s);
  endfunction

  function automatic logic [ND*4-1:0] f_packed();
    logic [ND*4-1:0] v;
    for (int k = 0; k < ND; k++) v[k*4 +: 4] = m_d[k];
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < ND; k++) m_d[k] = 4'd0;
    m_tff = 1'b0; m_win = 1'b0; m_ph = 0; m_tag = "R1";
  endtask

  task automatic model_step(input bit p, input bit r, input logic [ND*4-1:0] s);
    bit pulse, acc, live, c;
    int idx;
    logic [3:0] o, n;
    pulse = p && m_tff;
    if (p) m_tff = !m_tff;
    acc  = r && !m_win;
    live = m_win || acc;
    idx  = acc ? 0 : m_ph;
    if (pulse && live) begin
      for (int k = 0; k < ND; k++) begin
        if (idx < 2) m_d[k] = 4'hF;
        else if (idx >= 5) m_d[k] = f_preset(s[k*4 +: 4]);
      end
      m_tag = (idx < 2) ? "R7" : (idx < 5) ? "R8" : "R9";
      if (idx == 7) begin m_win = 1'b0; m_ph = 0; end
      else begin m_win = 1'b1; m_ph = idx + 1; end
    end else if (pulse) begin
      c = 1'b1;
      m_tag = "R3";
      for (int k = 0; k < ND; k++) begin
        if (c) begin
          o = m_d[k];
          n = (o == 4'd0) ? 4'd9 : o - 4'd1;
          m_d[k] = n;
          c = o[3] && !n[3];
          if (k > 0) m_tag = "R4";
        end
      end
    end else if (acc) begin
      m_win = 1'b1; m_ph = 0; m_tag = "R6";
    end else if (r && m_win) m_tag = "R10";
    else if (p) m_tag = "R2";
    else m_tag = "R11";
  endtask

  task automatic compare();
    logic [ND*4-1:0] e;
    logic ec;
    e  = f_packed();
    ec = ~m_d[ND-1][3];
    n_cmp++;
    if (digits !== e) begin
      n_bad++;
      $display("FAIL %s digits actual=%h expected=%h", m_tag, digits, e);
    end
    n_cmp++;
    if (count !== ec) begin
      n_bad++;
      $display("FAIL R5 count_o actual=%b expected=%b", count, ec);
    end
  endtask

  task automatic cyc(input bit p, input bit r, input logic [ND*4-1:0] s);
    @(negedge clk);
    in_pulse = p; req = r; sw = s;
    model_step(p, r, s);
    @(posedge clk);
    #2;
    compare();
  endtask

  initial begin
    void'($urandom(32'd5150));
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    compare();
    @(negedge clk);
    rst_ni = 1'b1;

    // R2: first input is swallowed, second counts (00 -> 09)
    cyc(1'b1, 1'b0, '0);
    cyc(1'b1, 1'b0, '0);
    // R4: run until low decade passes 8 -> 7
    repeat (12) cyc(1'b1, 1'b0, '0);

    // R3 R4 R5 random counting
    repeat (3000) cyc(1'($urandom % 2), 1'b0, '0);

    // R6..R9 directed window with clamped switch (hi=4, lo=12 -> 9)
    cyc(1'b0, 1'b1, 8'h4C);
    repeat (20) cyc(1'b1, 1'b0, 8'h4C);

    // R6 reload together with a counting pulse
    while (!m_tff) cyc(1'b1, 1'b0, 8'h27);
    cyc(1'b1, 1'b1, 8'h27);
    // R10 extra requests inside the window
    repeat (6) cyc(1'b1, 1'b1, 8'h27);
    repeat (30) cyc(1'b1, 1'b0, 8'h27);

    // R11 idle clocks
    repeat (20) cyc(1'b0, 1'b0, 8'h00);

    // mixed random
    repeat (20000) cyc(1'($urandom % 2), ($urandom % 40) == 0, 8'($urandom));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule